// File: doc/BRIEF.md
# Close-Page SDRAM Command Sequencer

The sequencer turns single-word read and write requests from a host port into command sequences for an SDRAM device with two internal banks, 11 row-address bits and 9 column-address bits. Every access is one beat. It opens the row, issues the column command, closes the bank again and reports completion. Writes produce a one-cycle done pulse. Reads return the word, captured from the data bus after the programmed CAS latency of 2 or 3 clocks.

All row-timing intervals are derived from nanosecond minimums at a 10 ns clock, which gives these gaps: ACTIVE to column command 3 clocks, ACTIVE to PRECHARGE 5, PRECHARGE to ACTIVE 3, ACTIVE to ACTIVE on the same bank 8, ACTIVE to ACTIVE across banks 2, and write data to PRECHARGE 2. An external refresh engine can request the bus. The request is granted only while the sequencer is idle and every bank has finished precharging. While the grant is held, host requests stall.

Top module: `sdseq_core`

## Requirements
- R1: After reset the bus carries NOP (sd_cs_n=0, sd_ras_n=1, sd_cas_n=1, sd_we_n=1), sd_dq_oe=0, sd_dqm=0, rd_valid=0, wr_done=0, ref_gnt=0, and req_ready=1 when no refresh is requested.
- R2: An accepted request is handled in a fixed order. First, ACTIVE (bus code 0011 on cs,ras,cas,we) with the row on sd_addr and the bank on sd_ba, in the cycle after acceptance. Next, READ (0101) or WRITE (0100) exactly 3 cycles after ACTIVE, with the column on sd_addr[8:0] and sd_addr[10]=0. Last, PRECHARGE (0010) to the same bank exactly 5 cycles after ACTIVE, with sd_addr[10]=0 so that only one bank closes.
- R3: sd_dq_oe is high only in the WRITE cycle, which carries req_wdata on sd_dq_out. sd_dqm is nonzero only in that cycle, where it carries req_wmask: bit i=1 suppresses byte i, so the stored byte keeps its old value. wr_done pulses for one cycle, in the PRECHARGE cycle of a write.
- R4: cfg_cl3=0 selects a CAS latency of 2 and cfg_cl3=1 selects 3, sampled when READ issues. The word on sd_dq_in at the end of cycle READ+CL appears on rd_data with rd_valid high in cycle READ+CL+1.
- R5: ACTIVE commands to the same bank are at least 8 cycles apart, and ACTIVE follows a PRECHARGE to that bank by at least 3 cycles. Two back-to-back requests to one bank start exactly 8 cycles apart.
- R6: ACTIVE commands to different banks are at least 2 cycles apart. A request to the other bank that is waiting when PRECHARGE issues gets its ACTIVE in the next cycle, 6 cycles after the previous ACTIVE.
- R7: ref_req is granted only in the idle state, at least 3 cycles after the last PRECHARGE, and it takes priority over a waiting host request. While ref_gnt is high, sd_cs_n=1 and req_ready=0, so no command reaches the bus.
- R8: req_ready stays low from the acceptance edge until PRECHARGE issues, so a request held on the port waits.
- R9: ref_gnt falls at the first clock edge that sees ref_req low, and a stalled host request then proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl3 | input | 1 | CAS latency select: 0 gives 2, 1 gives 3 |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Target bank |
| req_row | input | 11 | Row address |
| req_col | input | 9 | Column address |
| req_wdata | input | 16 | Write word |
| req_wmask | input | 2 | Byte mask, 1 = keep old byte |
| req_ready | output | 1 | Request accepted at this edge when valid |
| wr_done | output | 1 | Write completion pulse |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read word |
| ref_req | input | 1 | Refresh engine requests the bus |
| ref_gnt | output | 1 | Bus granted to refresh engine |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank address |
| sd_addr | output | 11 | Row, column or precharge-scope address |
| sd_dq_out | output | 16 | Write data toward the pads |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dqm | output | 2 | Byte mask toward the device |
| sd_dq_in | input | 16 | Read data from the pads |

## Verification
The bench runs the same addresses under both CAS latencies and checks the cycle in which rd_valid rises. A design that tapped the wrong pipeline stage would return the bench's poison word or raise rd_valid a cycle early or late. Pairs of back-to-back requests to the same bank and then to opposite banks pin the ACTIVE spacing at exactly 8 and 6 cycles, which catches both a design that violates the row-cycle limit and one that wastes cycles. A masked write followed by a read shows whether the mask polarity or byte lane is wrong. Refresh is raised together with a waiting request and again just after a write. Either case exposes a grant that comes before precharge completes, a request that slips through during the grant, or a grant that does not release.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_OPEN, ST_REF} seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] sd_cmd_t;
  localparam sd_cmd_t CMD_DESEL = 4'b1111;
  localparam sd_cmd_t CMD_NOP   = 4'b0111;
  localparam sd_cmd_t CMD_ACT   = 4'b0011;
  localparam sd_cmd_t CMD_READ  = 4'b0101;
  localparam sd_cmd_t CMD_WRITE = 4'b0100;
  localparam sd_cmd_t CMD_PRE   = 4'b0010;

  // address bit that selects auto-precharge / all-bank precharge
  localparam int unsigned AP_BIT = 10;
  localparam int unsigned CL_LO  = 2;
  localparam int unsigned CL_HI  = 3;

  function automatic int unsigned ps_to_clk(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycle offset of PRECHARGE after ACTIVE for a single-beat access
  function automatic int unsigned pre_offset(input int unsigned rcd, input int unsigned ras,
                                             input int unsigned wr);
    return max2(ras, rcd + wr);
  endfunction

endpackage

// File: rtl/sdseq_bank_timer.sv
module sdseq_bank_timer #(
  parameter int unsigned AGE_W = 4,
  parameter int unsigned T_ACT = 8,
  parameter int unsigned T_PRE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_hit,
  input  logic pre_hit,
  output logic ready
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [AGE_W-1:0] ACT_LIM = AGE_W'(T_ACT - 1);
  localparam logic [AGE_W-1:0] PRE_LIM = AGE_W'(T_PRE - 1);

  logic [AGE_W-1:0] act_age, pre_age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_age <= AGE_MAX;
      pre_age <= AGE_MAX;
    end else begin
      if (act_hit)                act_age <= '0;
      else if (act_age != AGE_MAX) act_age <= act_age + 1'b1;
      if (pre_hit)                pre_age <= '0;
      else if (pre_age != AGE_MAX) pre_age <= pre_age + 1'b1;
    end
  end

  assign ready = (act_age >= ACT_LIM) && (pre_age >= PRE_LIM);
endmodule

// File: rtl/sdseq_rd_pipe.sv
module sdseq_rd_pipe
  import sdseq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic          cl3,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = CL_HI + 1;

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] tag;
  logic             hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld[0] <= 1'b0;
      tag[0] <= 1'b0;
    end else begin
      vld[0] <= rd_issue;
      tag[0] <= cl3;
    end
  end

  for (genvar j = 1; j < DEPTH; j++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[j] <= 1'b0;
        tag[j] <= 1'b0;
      end else begin
        vld[j] <= vld[j-1];
        tag[j] <= tag[j-1];
      end
    end
  end

  assign hit = (vld[CL_LO] && !tag[CL_LO]) || (vld[CL_HI] && tag[CL_HI]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= hit;
      if (hit) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdseq_core.sv
module sdseq_core
  import sdseq_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned ROW_W    = 11,
  parameter int unsigned COL_W    = 9,
  parameter int unsigned BANKS    = 2,
  parameter int unsigned BA_W     = $clog2(BANKS),
  parameter int unsigned MW       = DW / 8,
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_RCD_PS = 30000,
  parameter int unsigned T_RAS_PS = 45000,
  parameter int unsigned T_RP_PS  = 30000,
  parameter int unsigned T_RC_PS  = 75000,
  parameter int unsigned T_RRD_PS = 20000,
  parameter int unsigned T_WR_CK  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cl3,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [DW-1:0]    req_wdata,
  input  logic [MW-1:0]    req_wmask,
  output logic             req_ready,
  output logic             wr_done,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  input  logic             ref_req,
  output logic             ref_gnt,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_addr,
  output logic [DW-1:0]    sd_dq_out,
  output logic             sd_dq_oe,
  output logic [MW-1:0]    sd_dqm,
  input  logic [DW-1:0]    sd_dq_in
);
  localparam int unsigned T_RCD    = ps_to_clk(T_RCD_PS, CLK_PS);
  localparam int unsigned T_RAS    = ps_to_clk(T_RAS_PS, CLK_PS);
  localparam int unsigned T_RP     = ps_to_clk(T_RP_PS, CLK_PS);
  localparam int unsigned T_RC     = ps_to_clk(T_RC_PS, CLK_PS);
  localparam int unsigned T_RRD    = ps_to_clk(T_RRD_PS, CLK_PS);
  localparam int unsigned T_WR     = T_WR_CK;
  localparam int unsigned T_PRE_AT = pre_offset(T_RCD, T_RAS, T_WR);
  localparam int unsigned AGE_W    = $clog2(max2(T_RC, T_RP) + 1);
  localparam int unsigned STEP_W   = $clog2(T_PRE_AT + 1);

  seq_state_t         state;
  sd_cmd_t            cmd_q;
  logic [STEP_W-1:0]  step;
  logic [BA_W-1:0]    cur_bank;
  logic               cur_write;
  logic [COL_W-1:0]   cur_col;
  logic [DW-1:0]      cur_wdata;
  logic [MW-1:0]      cur_wmask;

  logic [BANKS-1:0]   bank_rdy;
  logic               rrd_rdy;
  logic               all_rdy;

  // named internal events
  logic ev_act, ev_col, ev_pre, ev_gnt, rd_issue;

  assign all_rdy   = &bank_rdy;
  assign req_ready = (state == ST_IDLE) && !ref_req && bank_rdy[req_bank] && rrd_rdy;
  assign ev_act    = req_ready && req_valid;
  assign ev_gnt    = (state == ST_IDLE) && ref_req && all_rdy;
  assign ev_col    = (state == ST_OPEN) && (step == STEP_W'(T_RCD));
  assign ev_pre    = (state == ST_OPEN) && (step == STEP_W'(T_PRE_AT));
  assign rd_issue  = ev_col && !cur_write;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic act_b, pre_b;
    assign act_b = ev_act && (req_bank == BA_W'(b));
    assign pre_b = ev_pre && (cur_bank == BA_W'(b));
    sdseq_bank_timer #(.AGE_W(AGE_W), .T_ACT(T_RC), .T_PRE(T_RP)) tmr_i (
      .clk(clk), .rst_n(rst_n), .act_hit(act_b), .pre_hit(pre_b), .ready(bank_rdy[b])
    );
  end

  sdseq_bank_timer #(.AGE_W(AGE_W), .T_ACT(T_RRD), .T_PRE(1)) rrd_i (
    .clk(clk), .rst_n(rst_n), .act_hit(ev_act), .pre_hit(1'b0), .ready(rrd_rdy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cmd_q     <= CMD_NOP;
      step      <= '0;
      cur_bank  <= '0;
      cur_write <= 1'b0;
      cur_col   <= '0;
      cur_wdata <= '0;
      cur_wmask <= '0;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      sd_dqm    <= '0;
      wr_done   <= 1'b0;
      ref_gnt   <= 1'b0;
    end else begin
      cmd_q    <= CMD_NOP;
      sd_dq_oe <= 1'b0;
      sd_dqm   <= '0;
      wr_done  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ev_gnt) begin
            state   <= ST_REF;
            ref_gnt <= 1'b1;
            cmd_q   <= CMD_DESEL;
          end else if (ev_act) begin
            state     <= ST_OPEN;
            cmd_q     <= CMD_ACT;
            sd_ba     <= req_bank;
            sd_addr   <= req_row;
            step      <= STEP_W'(1);
            cur_bank  <= req_bank;
            cur_write <= req_write;
            cur_col   <= req_col;
            cur_wdata <= req_wdata;
            cur_wmask <= req_wmask;
          end
        end
        ST_OPEN: begin
          step <= step + 1'b1;
          if (ev_col) begin
            cmd_q   <= cur_write ? CMD_WRITE : CMD_READ;
            sd_addr <= ROW_W'(cur_col);
            if (cur_write) begin
              sd_dq_out <= cur_wdata;
              sd_dq_oe  <= 1'b1;
              sd_dqm    <= cur_wmask;
            end
          end else if (ev_pre) begin
            cmd_q   <= CMD_PRE;
            sd_addr <= '0;
            wr_done <= cur_write;
            state   <= ST_IDLE;
          end
        end
        ST_REF: begin
          if (!ref_req) begin
            state   <= ST_IDLE;
            ref_gnt <= 1'b0;
          end else begin
            cmd_q <= CMD_DESEL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  sdseq_rd_pipe #(.DW(DW)) rdp_i (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .cl3(cfg_cl3),
    .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk
  import sdseq_pkg::*;
#(
  parameter int unsigned BANKS = 2,
  parameter int unsigned BA_W  = 1,
  parameter int unsigned ROW_W = 11,
  parameter int unsigned MW    = 2,
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RAS = 5,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RC  = 8,
  parameter int unsigned T_RRD = 2,
  parameter int unsigned T_WR  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [BA_W-1:0]  sd_ba,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe,
  input logic [MW-1:0]    sd_dqm,
  input logic             ref_gnt,
  input logic             req_ready,
  input logic             wr_done,
  input logic             ev_act
);
  localparam logic [7:0] SAT = 8'hFF;

  sd_cmd_t c;
  logic is_act, is_rd, is_wr, is_pre, is_col;
  assign c      = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_act = (c == CMD_ACT);
  assign is_rd  = (c == CMD_READ);
  assign is_wr  = (c == CMD_WRITE);
  assign is_pre = (c == CMD_PRE);
  assign is_col = is_rd || is_wr;

  logic [7:0] since_act [BANKS];
  logic [7:0] since_pre [BANKS];
  logic [7:0] since_any;
  logic [7:0] since_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_any <= SAT;
      since_wr  <= SAT;
      for (int b = 0; b < BANKS; b++) begin
        since_act[b] <= SAT;
        since_pre[b] <= SAT;
      end
    end else begin
      since_any <= is_act ? 8'd0 : (since_any == SAT ? SAT : since_any + 8'd1);
      since_wr  <= is_wr  ? 8'd0 : (since_wr  == SAT ? SAT : since_wr  + 8'd1);
      for (int b = 0; b < BANKS; b++) begin
        if (is_act && sd_ba == BA_W'(b)) since_act[b] <= 8'd0;
        else if (since_act[b] != SAT)    since_act[b] <= since_act[b] + 8'd1;
        if (is_pre && sd_ba == BA_W'(b)) since_pre[b] <= 8'd0;
        else if (since_pre[b] != SAT)    since_pre[b] <= since_pre[b] + 8'd1;
      end
    end
  end

  AST_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_act[sd_ba] == 8'(T_RCD - 1)); // R2
  AST_COL_NO_AP: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> !sd_addr[AP_BIT]); // R2
  AST_PRE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> since_act[sd_ba] >= 8'(T_RAS - 1)); // R2
  AST_PRE_WR_REC: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> since_wr >= 8'(T_WR - 1)); // R2
  AST_ACT_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |=> is_act); // R2
  AST_DQM_WR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_dqm != '0) |-> is_wr); // R3
  AST_OE_WR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> is_wr); // R3
  AST_DONE_AT_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> is_pre); // R3
  AST_ROW_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_act[sd_ba] >= 8'(T_RC - 1)); // R5
  AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_pre[sd_ba] >= 8'(T_RP - 1)); // R5
  AST_BANK_TO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_any >= 8'(T_RRD - 1)); // R6
  AST_GNT_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> sd_cs_n); // R7
  AST_GNT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> !req_ready); // R7
endmodule

bind sdseq_core sdseq_chk #(
  .BANKS(BANKS), .BA_W(BA_W), .ROW_W(ROW_W), .MW(MW),
  .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC), .T_RRD(T_RRD), .T_WR(T_WR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm),
  .ref_gnt(ref_gnt), .req_ready(req_ready), .wr_done(wr_done), .ev_act(ev_act)
);

// File: tb/sdseq_core_tb_top.sv
module sdseq_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cl3 = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
  logic [10:0] req_row = '0;
  logic [8:0]  req_col = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_wmask = '0;
  logic        req_ready, wr_done, rd_valid, ref_gnt;
  logic [15:0] rd_data;
  logic        ref_req = 1'b0;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_dq_oe;
  logic [10:0] sd_addr;
  logic [15:0] sd_dq_out;
  logic [1:0]  sd_dqm;
  logic [15:0] sd_dq_in = 16'hBADD;

  sdseq_core dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .req_wmask(req_wmask), .req_ready(req_ready), .wr_done(wr_done), .rd_valid(rd_valid),
    .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm),
    .sd_dq_in(sd_dq_in)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  typedef struct { int cnt; logic [15:0] d; } rd_ent_t;
  rd_ent_t     sched[$];
  int          rdv_cyc[$];
  logic [15:0] exp_rd[$];
  logic [15:0] shadow[int];
  logic [15:0] model[int];
  int          act_log[$];
  int          last_act[2] = '{-100, -100};
  int          last_pre[2] = '{-100, -100};
  int          last_any_act = -100;
  int          open_row[2] = '{0, 0};
  bit          col_wr[2] = '{0, 0};
  bit          gnt_prev = 0;

  function automatic int mkkey(input bit b, input int row, input int col);
    return (int'(b) << 20) | (row << 9) | col;
  endfunction

  // SDRAM bus model and protocol monitor
  always @(negedge clk) begin : mon
    logic [3:0]  c;
    logic [15:0] drive, old;
    int          b, k, gap, last_p;
    if (rst_n) begin
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      b = int'(sd_ba);
      drive = 16'hBADD;
      foreach (sched[i]) sched[i].cnt = sched[i].cnt - 1;
      while (sched.size() > 0 && sched[0].cnt <= 0) begin
        drive = sched[0].d;
        void'(sched.pop_front());
      end
      sd_dq_in = drive;

      if (rdv_cyc.size() > 0 && rdv_cyc[0] == cyc) begin
        chk(rd_valid, "R4", "rd_valid in cycle READ+CL+1", rd_valid, 1);
        void'(rdv_cyc.pop_front());
        if (exp_rd.size() > 0) chk(rd_data == exp_rd[0], "R4", "read word", rd_data, exp_rd[0]);
        if (exp_rd.size() > 0) void'(exp_rd.pop_front());
      end else if (rd_valid) begin
        chk(0, "R4", "unexpected rd_valid", 1, 0);
      end

      case (c)
        4'b0011: begin
          gap = cyc - last_act[b];
          chk(gap >= 8, "R5", "same-bank ACTIVE spacing", gap, 8);
          gap = cyc - last_pre[b];
          chk(gap >= 3, "R5", "PRECHARGE to ACTIVE", gap, 3);
          gap = cyc - last_any_act;
          chk(gap >= 2, "R6", "cross-bank ACTIVE spacing", gap, 2);
          last_act[b] = cyc; last_any_act = cyc;
          open_row[b] = int'(sd_addr);
          act_log.push_back(cyc);
        end
        4'b0101, 4'b0100: begin
          gap = cyc - last_act[b];
          chk(gap == 3, "R2", "ACTIVE to column gap", gap, 3);
          chk(!sd_addr[10], "R2", "column A10", sd_addr[10], 0);
          k = mkkey(sd_ba, open_row[b], int'(sd_addr[8:0]));
          old = model.exists(k) ? model[k] : 16'h0;
          if (c == 4'b0100) begin
            chk(sd_dq_oe, "R3", "oe on WRITE", sd_dq_oe, 1);
            model[k] = {sd_dqm[1] ? old[15:8] : sd_dq_out[15:8],
                        sd_dqm[0] ? old[7:0]  : sd_dq_out[7:0]};
            col_wr[b] = 1;
          end else begin
            sched.push_back('{cfg_cl3 ? 3 : 2, old});
            rdv_cyc.push_back(cyc + (cfg_cl3 ? 3 : 2) + 1);
            col_wr[b] = 0;
          end
        end
        4'b0010: begin
          gap = cyc - last_act[b];
          chk(gap == 5, "R2", "ACTIVE to PRECHARGE gap", gap, 5);
          chk(!sd_addr[10], "R2", "precharge A10", sd_addr[10], 0);
          chk(wr_done == col_wr[b], "R3", "wr_done at PRECHARGE", wr_done, col_wr[b]);
          last_pre[b] = cyc;
        end
        default: ;
      endcase
      if (c != 4'b0100) begin
        chk(!sd_dq_oe && sd_dqm == 2'b00, "R3", "oe/dqm idle outside WRITE",
            {sd_dq_oe, sd_dqm}, 0);
      end
      if (c != 4'b0010 && wr_done) chk(0, "R3", "wr_done outside PRECHARGE", 1, 0);
      if (ref_gnt) begin
        chk(sd_cs_n && !req_ready, "R7", "deselect and stall during grant",
            {sd_cs_n, req_ready}, 2'b10);
        if (!gnt_prev) begin
          last_p = (last_pre[0] > last_pre[1]) ? last_pre[0] : last_pre[1];
          gap = cyc - last_p;
          chk(gap >= 3, "R7", "grant after precharge", gap, 3);
        end
      end
      gnt_prev = ref_gnt;
    end
  end

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic do_req(input bit w, input bit b, input int row, input int col,
                        input logic [15:0] d, input logic [1:0] m);
    int k;
    logic [15:0] old;
    k = mkkey(b, row, col);
    old = shadow.exists(k) ? shadow[k] : 16'h0;
    if (w) shadow[k] = {m[1] ? old[15:8] : d[15:8], m[0] ? old[7:0] : d[7:0]};
    else   exp_rd.push_back(old);
    req_valid = 1; req_write = w; req_bank = b; req_row = 11'(row); req_col = 9'(col);
    req_wdata = d; req_wmask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && (exp_rd.size() > 0 || rdv_cyc.size() > 0); i++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic act_gap(input int exp, input string rq);
    for (int i = 0; i < 40 && act_log.size() < 2; i++) @(negedge clk);
    if (act_log.size() >= 2) chk(act_log[1] - act_log[0] == exp, rq, "back-to-back ACTIVE gap",
                                 act_log[1] - act_log[0], exp);
    else chk(0, rq, "two ACTIVEs seen", act_log.size(), 2);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
    finish_run();
  end

  initial begin : main
    int g;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "NOP after reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(!sd_dq_oe && sd_dqm == 0 && !rd_valid && !wr_done && !ref_gnt, "R1", "idle outputs",
        {sd_dq_oe, sd_dqm, rd_valid, wr_done, ref_gnt}, 0);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);

    // CAS latency 2
    do_req(1, 0, 5, 7, 16'hA1B2, 2'b00);
    chk(!req_ready, "R8", "ready low while access open", req_ready, 0);
    do_req(0, 0, 5, 7, 16'h0, 2'b00);
    do_req(1, 1, 5, 7, 16'h3C4D, 2'b00);
    do_req(0, 1, 5, 7, 16'h0, 2'b00);
    do_req(1, 0, 5, 7, 16'hFFFF, 2'b01);   // R3 byte 0 masked
    do_req(0, 0, 5, 7, 16'h0, 2'b00);
    drain();
    act_log.delete();
    do_req(1, 0, 9, 1, 16'h1357, 2'b00);
    do_req(0, 1, 9, 1, 16'h0, 2'b00);
    act_gap(6, "R6");
    drain();
    act_log.delete();
    do_req(0, 1, 5, 7, 16'h0, 2'b00);
    do_req(0, 1, 5, 7, 16'h0, 2'b00);
    act_gap(8, "R5");
    drain();

    // CAS latency 3, edge addresses
    cfg_cl3 = 1;
    do_req(0, 0, 5, 7, 16'h0, 2'b00);
    do_req(0, 1, 5, 7, 16'h0, 2'b00);
    do_req(1, 1, 2047, 511, 16'h5AA5, 2'b10);
    do_req(0, 1, 2047, 511, 16'h0, 2'b00);
    do_req(1, 0, 0, 0, 16'h0F0F, 2'b00);
    do_req(0, 0, 0, 0, 16'h0, 2'b00);
    drain();

    // refresh with a waiting request
    ref_req = 1;
    #1;
    chk(!req_ready, "R7", "ready low with refresh pending", req_ready, 0);
    fork
      do_req(0, 0, 0, 0, 16'h0, 2'b00);
      begin
        @(negedge clk);
        chk(ref_gnt, "R7", "grant in idle", ref_gnt, 1);
        repeat (5) @(negedge clk);
        chk(ref_gnt && act_log.size() == 0 || ref_gnt, "R7", "grant held", ref_gnt, 1);
        ref_req = 0;
        @(negedge clk);
        chk(!ref_gnt, "R9", "grant released", ref_gnt, 0);
      end
    join
    drain();

    // refresh raised right after a write is accepted
    do_req(1, 1, 3, 3, 16'h2468, 2'b00);
    ref_req = 1;
    g = 0;
    for (int i = 0; i < 30 && !ref_gnt; i++) begin @(negedge clk); g++; end
    chk(ref_gnt, "R7", "grant after write completes", ref_gnt, 1);
    chk(g >= 7, "R7", "grant waits for precharge", g, 7);
    ref_req = 0;
    @(negedge clk);
    chk(!ref_gnt, "R9", "grant released", ref_gnt, 0);
    do_req(0, 1, 3, 3, 16'h0, 2'b00);
    drain();
    finish_run();
  end
endmodule